// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB panel. Running on the pixel clock, it walks every line through five phases: a lead-in of one or more cycles before the sync pulse, the sync pulse itself, the back porch, the visible pixels and the front porch. It walks every frame through the same five phases counted in whole lines. From that position it drives horizontal sync, vertical sync, data-enable, the coordinates of the current visible pixel and a one-cycle pulse on the first visible pixel of each frame. Pixel fetch and scaling belong to the logic that consumes these outputs.

Timing comes from five 32-bit configuration words. Four hold the lead-in, sync width, back porch and front porch, and one holds the visible size. Each word carries the horizontal value in its low half and the vertical value in its high half. Software normally programs a lead-in of 1 on both axes and subtracts that cycle from the panel's nominal front porch, so the line and frame totals stay those of the panel. The words are plain level inputs with no handshake. They are sampled into a shadow copy on the first clock after reset and again at each frame boundary, so a change made mid-frame never tears the raster. No data stream enters or leaves the block, so there is no valid/ready interface and no back-pressure.

Top module: `lcd_timing_gen`

## Requirements
- R1: While rst_n is low, hsync, vsync, de and frame_start are 0, and px_x and px_y are 0.
- R2: In every configuration word, bits 15:0 hold the horizontal value in pixel clocks and bits 31:16 hold the vertical value in lines.
- R3: A line is the lead-in, then sync, then back porch, then visible, then front porch. Each phase lasts its horizontal field in cycles, and a field of 0 acts as 1, so the line period is the sum of the five fields.
- R4: hsync is active high and is 1 exactly during the horizontal sync phase of every line.
- R5: The frame runs through the same five phases in whole lines, and vsync is active high for every cycle of the lines in the vertical sync phase.
- R6: de is 1 only when both the horizontal and the vertical position are in their visible phase, and 0 at all other times.
- R7: During de, px_x counts 0 upward across the visible pixels of a line and px_y counts 0 upward across the visible lines of a frame. Both are 0 while de is 0.
- R8: frame_start is a single-cycle pulse on the first visible pixel of each frame, where px_x and px_y are both 0.
- R9: The configuration inputs are captured on the first clock after reset is released and then only on the last cycle of each frame. A change at any other time first shows in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tm_lead | input | 32 | Lead-in before sync: vertical[31:16], horizontal[15:0] |
| tm_pulse | input | 32 | Sync width: vertical[31:16], horizontal[15:0] |
| tm_back | input | 32 | Back porch: vertical[31:16], horizontal[15:0] |
| tm_front | input | 32 | Front porch: vertical[31:16], horizontal[15:0] |
| tm_visible | input | 32 | Visible size: height[31:16], width[15:0] |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, high on visible pixels |
| px_x | output | 16 | Visible pixel column, 0 outside de |
| px_y | output | 16 | Visible line number, 0 outside de |
| frame_start | output | 1 | Pulse on the first visible pixel of a frame |

## Verification
A behavioural model holds a single position counter per axis and derives each output from the sum of the phase lengths. The bench compares that model with the outputs on every cycle. Three configurations are used. The first has a different value in every horizontal and vertical field, so a swapped half or a swapped phase changes the measured sync width and line period. The second is written in the middle of a frame: the line period must keep its old value until the next frame_start and then switch, which separates capture at the frame boundary from immediate capture. The third sets several fields to zero, which tests the rule that a zero field lasts one cycle.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
  // Phase order inside a line and inside a frame; the index also selects
  // the configuration word that sets the phase length.
  typedef enum logic [2:0] {
    PH_LEAD  = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_VIS   = 3'd3,
    PH_FRONT = 3'd4
  } phase_e;

  localparam int NUM_PHASES = 5;
  localparam int NUM_AXES   = 2;
endpackage

// File: rtl/lcdtg_shadow.sv
module lcdtg_shadow
  import lcdtg_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [NUM_PHASES-1:0][2*FW-1:0]      cfg,
  output logic [NUM_AXES-1:0][NUM_PHASES-1:0][FW-1:0] len_q
);
  logic [NUM_AXES-1:0][NUM_PHASES-1:0][FW-1:0] len_d;

  // Axis g takes half g of every word: 0 = horizontal, 1 = vertical.
  for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
      assign len_d[g][p] = cfg[p][g*FW +: FW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (load) len_q <= len_d;
  end

  // R9: timing copy only moves on a load cycle
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(len_q));
endmodule

// File: rtl/lcdtg_axis.sv
module lcdtg_axis
  import lcdtg_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             step,
  input  logic [NUM_PHASES-1:0][FW-1:0]    lens,
  output phase_e                           phase,
  output logic [FW-1:0]                    cnt,
  output logic                             wrap
);
  logic [FW-1:0] cur_len;
  logic [FW:0]   cnt_inc;
  logic          phase_end;
  phase_e        phase_nxt;

  always_comb begin
    unique case (phase)
      PH_LEAD:  begin cur_len = lens[0]; phase_nxt = PH_SYNC;  end
      PH_SYNC:  begin cur_len = lens[1]; phase_nxt = PH_BACK;  end
      PH_BACK:  begin cur_len = lens[2]; phase_nxt = PH_VIS;   end
      PH_VIS:   begin cur_len = lens[3]; phase_nxt = PH_FRONT; end
      default:  begin cur_len = lens[4]; phase_nxt = PH_LEAD;  end
    endcase
  end

  // A zero length ends the phase after one step, like a length of one.
  assign cnt_inc   = {1'b0, cnt} + 1'b1;
  assign phase_end = cnt_inc >= {1'b0, cur_len};
  assign wrap      = step && (phase == PH_FRONT) && phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LEAD;
      cnt   <= '0;
    end else if (step) begin
      if (phase_end) begin
        phase <= phase_nxt;
        cnt   <= '0;
      end else begin
        cnt <= cnt_inc[FW-1:0];
      end
    end
  end

  // R3: position frozen without a step
  assert_axis_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase) && $stable(cnt));

  // R3: offset stays inside the current phase length
  assert_axis_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_len == '0) ? (cnt == '0) : (cnt < cur_len));

  // R3: phase order is fixed
  assert_axis_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_SYNC && phase_end) |=> (phase == PH_BACK));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdtg_pkg::*;
#(
  parameter int FW = 16,
  localparam int WW = 2 * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] tm_lead,
  input  logic [WW-1:0] tm_pulse,
  input  logic [WW-1:0] tm_back,
  input  logic [WW-1:0] tm_front,
  input  logic [WW-1:0] tm_visible,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [FW-1:0] px_x,
  output logic [FW-1:0] px_y,
  output logic          frame_start
);
  logic [NUM_PHASES-1:0][WW-1:0]               cfg;
  logic [NUM_AXES-1:0][NUM_PHASES-1:0][FW-1:0] sh_len;
  logic                                        primed;
  logic                                        load;
  logic   ax_step [NUM_AXES];
  logic   ax_wrap [NUM_AXES];
  phase_e ax_phase[NUM_AXES];
  logic [FW-1:0] ax_cnt[NUM_AXES];

  assign cfg[0] = tm_lead;
  assign cfg[1] = tm_pulse;
  assign cfg[2] = tm_back;
  assign cfg[3] = tm_visible;
  assign cfg[4] = tm_front;

  // First clock after reset captures the timing; afterwards the last cycle
  // of every frame does.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assign load = !primed || ax_wrap[NUM_AXES-1];

  lcdtg_shadow #(.FW(FW)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .cfg   (cfg),
    .len_q (sh_len)
  );

  // Horizontal axis steps every primed cycle; each further axis steps when
  // the one below it wraps.
  for (genvar g = 0; g < NUM_AXES; g++) begin : g_ax
    if (g == 0) begin : g_first
      assign ax_step[g] = primed;
    end else begin : g_next
      assign ax_step[g] = ax_wrap[g-1];
    end

    lcdtg_axis #(.FW(FW)) u_axis (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (ax_step[g]),
      .lens  (sh_len[g]),
      .phase (ax_phase[g]),
      .cnt   (ax_cnt[g]),
      .wrap  (ax_wrap[g])
    );
  end

  assign hsync       = (ax_phase[0] == PH_SYNC);
  assign vsync       = (ax_phase[1] == PH_SYNC);
  assign de          = (ax_phase[0] == PH_VIS) && (ax_phase[1] == PH_VIS);
  assign px_x        = de ? ax_cnt[0] : '0;
  assign px_y        = de ? ax_cnt[1] : '0;
  assign frame_start = de && (ax_cnt[0] == '0) && (ax_cnt[1] == '0);

  // R6: data never overlaps either sync pulse
  assert_de_nosync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !hsync && !vsync);

  // R8: frame start is a single cycle
  assert_fs_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R7: column stays inside the visible width
  assert_px_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (px_x < sh_len[0][3]) || (px_x == '0));

  // R9: a new frame always starts from the lead-in on both axes
  assert_frame_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ax_wrap[NUM_AXES-1] |=> (ax_phase[0] == PH_LEAD) && (ax_phase[1] == PH_LEAD)
                            && (ax_cnt[0] == '0) && (ax_cnt[1] == '0));
endmodule

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tm_lead = '0, tm_pulse = '0, tm_back = '0, tm_front = '0, tm_visible = '0;
  logic        hsync, vsync, de, frame_start;
  logic [15:0] px_x, px_y;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  lcd_timing_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .tm_lead(tm_lead), .tm_pulse(tm_pulse), .tm_back(tm_back),
    .tm_front(tm_front), .tm_visible(tm_visible),
    .hsync(hsync), .vsync(vsync), .de(de),
    .px_x(px_x), .px_y(px_y), .frame_start(frame_start)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int hl[5], vl[5];   // effective lengths: lead, sync, back, visible, front
  int hx = 0, vy = 0; // position in line (cycles) and frame (lines)
  bit m_primed = 0;

  function automatic int eff(logic [15:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int tot(int l[5]);
    return l[0] + l[1] + l[2] + l[3] + l[4];
  endfunction

  task automatic locate(input int l[5], input int pos, output int idx, output int off);
    idx = 0; off = pos;
    while (off >= l[idx]) begin off -= l[idx]; idx++; end
  endtask

  task automatic m_load();
    hl[0] = eff(tm_lead[15:0]);    vl[0] = eff(tm_lead[31:16]);
    hl[1] = eff(tm_pulse[15:0]);   vl[1] = eff(tm_pulse[31:16]);
    hl[2] = eff(tm_back[15:0]);    vl[2] = eff(tm_back[31:16]);
    hl[3] = eff(tm_visible[15:0]); vl[3] = eff(tm_visible[31:16]);
    hl[4] = eff(tm_front[15:0]);   vl[4] = eff(tm_front[31:16]);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_primed = 0; hx = 0; vy = 0;
    end else if (!m_primed) begin
      m_load(); m_primed = 1;
    end else begin
      hx++;
      if (hx == tot(hl)) begin
        hx = 0; vy++;
        if (vy == tot(vl)) begin vy = 0; m_load(); end
      end
    end
  end

  // per-cycle comparison and simple measurements
  int cyc = 0, last_hrise = -1, hper = 0, hs_run = 0, hs_len = 0, vs_run = 0, vs_len = 0;
  bit prev_h = 0, prev_v = 0;

  always @(negedge clk) begin
    int hi, ho, vi, vo;
    bit e_de;
    cyc++;
    if (rst_n && m_primed) begin
      locate(hl, hx, hi, ho);
      locate(vl, vy, vi, vo);
      e_de = (hi == 3) && (vi == 3);
      chk("R4", "hsync", hsync, hi == 1);
      chk("R5", "vsync", vsync, vi == 1);
      chk("R6", "de", de, e_de);
      chk("R7", "px_x", px_x, e_de ? ho : 0);
      chk("R7", "px_y", px_y, e_de ? vo : 0);
      chk("R8", "frame_start", frame_start, e_de && ho == 0 && vo == 0);
    end
    if (hsync && !prev_h) begin
      if (last_hrise >= 0) hper = cyc - last_hrise;
      last_hrise = cyc;
    end
    if (hsync) hs_run++; else if (prev_h) begin hs_len = hs_run; hs_run = 0; end
    if (vsync) vs_run++; else if (prev_v) begin vs_len = vs_run; vs_run = 0; end
    prev_h = hsync; prev_v = vsync;
  end

  // ---------------- stimulus ----------------
  task automatic set_cfg(int hr, int hs, int hb, int ha, int hf,
                         int vr, int vs, int vb, int va, int vf);
    @(posedge clk); #2;
    tm_lead    = {vr[15:0], hr[15:0]};
    tm_pulse   = {vs[15:0], hs[15:0]};
    tm_back    = {vb[15:0], hb[15:0]};
    tm_visible = {va[15:0], ha[15:0]};
    tm_front   = {vf[15:0], hf[15:0]};
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic wait_hrise();
    do @(negedge clk); while (!(hsync && !prev_h));
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    set_cfg(1, 2, 3, 5, 2, 1, 3, 2, 4, 1); // line 13 cycles, frame 11 lines
    repeat (3) @(negedge clk);
    chk("R1", "hsync", hsync, 0);
    chk("R1", "vsync", vsync, 0);
    chk("R1", "de", de, 0);
    chk("R1", "frame_start", frame_start, 0);
    chk("R1", "px_x", px_x, 0);
    chk("R1", "px_y", px_y, 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // Pattern A: distinct fields per half
    wait_fs(); wait_fs(); wait_fs();
    wait_hrise(); wait_hrise();
    chk("R3", "line period", hper, 13);
    chk("R2", "hsync width (low half)", hs_len, 2);
    chk("R2", "vsync width (high half lines)", vs_len, 3 * 13);

    // Pattern B written mid-frame: R9 deferred capture
    repeat (20) @(negedge clk);
    set_cfg(1, 4, 1, 6, 3, 1, 2, 1, 2, 2); // line 15, frame 8 lines
    wait_hrise(); wait_hrise();
    chk("R9", "old line period kept mid-frame", hper, 13);
    wait_fs();
    wait_hrise(); wait_hrise();
    chk("R9", "new line period after frame boundary", hper, 15);
    wait_fs(); wait_fs();
    chk("R2", "vsync width pattern B", vs_len, 2 * 15);

    // Pattern C: zero fields behave as one
    set_cfg(1, 0, 0, 3, 0, 1, 1, 0, 2, 0); // line 7, frame 6 lines
    wait_fs(); wait_fs(); wait_fs();
    wait_hrise(); wait_hrise();
    chk("R3", "line period with zero fields", hper, 7);
    chk("R4", "hsync width zero field", hs_len, 1);

    // Reset again mid-run
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "de in second reset", de, 0);
    chk("R1", "hsync in second reset", hsync, 0);
    #3 rst_n = 1'b1;
    wait_fs(); wait_fs();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule